// File: doc/BRIEF.md
# Serial Port Interrupt Status Latch

This block collects the event pulses from a serial port's transmit and receive paths and holds them in a small status register. Transmit requests, framing errors, received breaks and receive overruns are sticky. Each one stays set until software writes a one to its bit. The receive trigger and receive timeout bits behave differently. They are live copies of level inputs from the receive FIFO, and software clears them only by draining that FIFO.

A second register holds three interrupt enables:

- The error enable gates the framing, break and overrun bits.
- The receive enable gates the trigger and timeout bits.
- The transmit enable gates the transmit request.

The OR of all enabled status bits is registered and drives a single interrupt line.

Software reaches both registers through a simple word-addressed bus. Reads have no side effects. Writes take effect at the next clock edge.

Top module: `isr_latch_top`

## Requirements
- R1: After reset, every latched status bit, every enable bit and the interrupt output are zero.
- R2: A one-cycle pulse on the transmit request, framing, break or overrun input sets status bit 0, 3, 4 or 5 respectively. The bit reads as one from the next cycle and stays set without further input.
- R3: A write to the status address with a one in bit 0, 3, 4 or 5 clears that bit. A zero in that position leaves the bit unchanged.
- R4: When an event pulse and a clearing write for the same bit fall in the same cycle, the bit remains set.
- R5: Status bit 1 follows the receive trigger level and bit 2 follows the receive timeout level. Writes to the status address do not alter either bit.
- R6: Writing a one to status bit 6 sets status bit 0, and this takes priority over a clear of bit 0 in the same write. Bit 6 always reads as zero.
- R7: The control address holds the transmit enable at bit 5, the receive enable at bit 6 and the error enable at bit 7. All other bits of that word read as zero, and any address other than status (0) and control (1) reads as zero.
- R8: The interrupt output is one exactly one cycle after some status bit is set while its group enable is set. Bits 3, 4 and 5 use the error enable, bits 1 and 2 use the receive enable, and bit 0 uses the transmit enable.
- R9: Bits 31 down to 7 of the status word read as zero, and ones written there have no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Word address: 0 status, 1 control |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register |
| evTxReq | input | 1 | Transmit request event pulse |
| evFrameErr | input | 1 | Framing error event pulse |
| evBreak | input | 1 | Break received event pulse |
| evOverrun | input | 1 | Receive overrun event pulse |
| rxTrigLvl | input | 1 | Receive FIFO at trigger level (live) |
| rxTimeoutLvl | input | 1 | Receive inactivity timeout (live) |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The assertions assume that event inputs and bus strobes change only between clock edges and are clean single-bit levels. They also assume that a status write is marked by `busWrEn` together with address 0, never by a partially decoded address. The bench drives every input on the falling edge and holds each bus write for exactly one rising edge. This makes every set, clear and collision fall in a known cycle. Event pulses are one cycle wide, with one deliberate case where a pulse coincides with a clearing write.

// File: rtl/isr_pkg.sv
package isr_pkg;
  // status bit positions
  localparam int BIT_TXREQ  = 0;
  localparam int BIT_RXTRIG = 1;
  localparam int BIT_RXTMO  = 2;
  localparam int BIT_FRAME  = 3;
  localparam int BIT_BREAK  = 4;
  localparam int BIT_OVRN   = 5;
  localparam int BIT_TXSET  = 6;
  localparam int STAT_W     = 7;

  // enable positions inside the control word
  localparam int EN_LSB = 5;
  localparam int EN_W   = 3;
  localparam int GRP_TX  = 0;
  localparam int GRP_RX  = 1;
  localparam int GRP_ERR = 2;

  typedef enum logic [1:0] { BIT_LATCHED, BIT_LIVE, BIT_ACTION } bitKind_e;

  typedef struct packed {
    logic statWr;
    logic ctrlWr;
    logic rdStat;
    logic rdCtrl;
  } busStrobe_t;

  function automatic bitKind_e kindOf(input int idx);
    if (idx == BIT_RXTRIG || idx == BIT_RXTMO) return BIT_LIVE;
    if (idx == BIT_TXSET) return BIT_ACTION;
    return BIT_LATCHED;
  endfunction

  function automatic int groupOf(input int idx);
    if (idx == BIT_TXREQ) return GRP_TX;
    if (idx == BIT_RXTRIG || idx == BIT_RXTMO) return GRP_RX;
    return GRP_ERR;
  endfunction
endpackage

// File: rtl/isr_sticky_bit.sv
module isr_sticky_bit (
  input  logic clk,
  input  logic rstN,
  input  logic setPulse,
  input  logic clrStrobe,
  output logic q
);
  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)          q <= 1'b0;
    else if (setPulse)  q <= 1'b1;
    else if (clrStrobe) q <= 1'b0;
  end
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic hitStat, hitCtrl;

  always_comb begin
    hitStat = (busAddr == STAT_A);
    hitCtrl = (busAddr == CTRL_A);
    strobe.statWr = busWrEn && hitStat;
    strobe.ctrlWr = busWrEn && hitCtrl;
    strobe.rdStat = hitStat;
    strobe.rdCtrl = hitCtrl;
  end
endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STAT_W-1:0] evVec,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] statusVec,
  output logic [EN_W-1:0]   enVec,
  output logic              irqQ
);
  localparam int PAD_STAT = DATA_W - STAT_W;
  localparam int PAD_CTRL = DATA_W - EN_LSB - EN_W;

  logic                txSetWr;
  logic [STAT_W-1:0]   gateVec;

  assign txSetWr = strobe.statWr && wrData[BIT_TXSET];

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (kindOf(i) == BIT_LATCHED) begin : g_lat
      logic setI;
      if (i == BIT_TXREQ) begin : g_tx
        assign setI = evVec[i] | txSetWr;
      end else begin : g_ev
        assign setI = evVec[i];
      end
      isr_sticky_bit u_bit (
        .clk       (clk),
        .rstN      (rstN),
        .setPulse  (setI),
        .clrStrobe (strobe.statWr && wrData[i]),
        .q         (statusVec[i])
      );
    end else if (kindOf(i) == BIT_LIVE) begin : g_live
      assign statusVec[i] = evVec[i];
    end else begin : g_act
      assign statusVec[i] = 1'b0;
    end
    assign gateVec[i] = enVec[groupOf(i)];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              enVec <= '0;
    else if (strobe.ctrlWr) enVec <= wrData[EN_LSB +: EN_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusVec & gateVec);
  end

  always_comb begin
    if (strobe.rdStat)      rdData = {{PAD_STAT{1'b0}}, statusVec};
    else if (strobe.rdCtrl) rdData = {{PAD_CTRL{1'b0}}, enVec, {EN_LSB{1'b0}}};
    else                    rdData = '0;
  end
endmodule

// File: rtl/isr_latch_top.sv
module isr_latch_top
  import isr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              evTxReq,
  input  logic              evFrameErr,
  input  logic              evBreak,
  input  logic              evOverrun,
  input  logic              rxTrigLvl,
  input  logic              rxTimeoutLvl,
  output logic              irqOut
);
  busStrobe_t        strobe;
  logic [STAT_W-1:0] evVec;
  logic [STAT_W-1:0] statusVec;
  logic [EN_W-1:0]   enVec;

  assign evVec = {1'b0, evOverrun, evBreak, evFrameErr, rxTimeoutLvl, rxTrigLvl, evTxReq};

  isr_ctrl #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  isr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .evVec     (evVec),
    .rdData    (busRdData),
    .statusVec (statusVec),
    .enVec     (enVec),
    .irqQ      (irqOut)
  );
endmodule

// File: rtl/isr_latch_chk.sv
module isr_latch_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              evTxReq,
  input logic              evFrameErr,
  input logic              evBreak,
  input logic              irqOut,
  input logic [6:0]        statusVec,
  input logic [2:0]        enVec
);
  logic statWr;
  assign statWr = busWrEn && (busAddr == ADDR_W'(STAT_ADDR));

  p_break_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    evBreak |=> statusVec[4]);
  p_txreq_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    evTxReq |=> statusVec[0]);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && busWrData[4] && !evBreak) |=> !statusVec[4]);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!evBreak && !(statWr && busWrData[4])) |=> $stable(statusVec[4]));
  p_collide_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && busWrData[3] && evFrameErr) |=> statusVec[3]);
  p_txset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && busWrData[6]) |=> statusVec[0]);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enVec) == 3'b000) |-> !irqOut);
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:8] == '0);
endmodule

bind isr_latch_top isr_latch_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .evTxReq    (evTxReq),
  .evFrameErr (evFrameErr),
  .evBreak    (evBreak),
  .irqOut     (irqOut),
  .statusVec  (statusVec),
  .enVec      (enVec)
);

// File: tb/sim_isr_latch_top.sv
`timescale 1ns/1ps
module sim_isr_latch_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        evTxReq = 0, evFrameErr = 0, evBreak = 0, evOverrun = 0;
  logic        rxTrigLvl = 0, rxTimeoutLvl = 0;
  logic        irqOut;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  isr_latch_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .evTxReq(evTxReq), .evFrameErr(evFrameErr), .evBreak(evBreak),
    .evOverrun(evOverrun), .rxTrigLvl(rxTrigLvl), .rxTimeoutLvl(rxTimeoutLvl),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecCnt++;
    if (got !== exp) begin
      errCnt++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdData;
  endtask

  // mask bits: 0 txReq, 3 frame, 4 break, 5 overrun
  task automatic pulse(input logic [5:0] m);
    evTxReq = m[0]; evFrameErr = m[3]; evBreak = m[4]; evOverrun = m[5];
    @(negedge clk);
    evTxReq = 0; evFrameErr = 0; evBreak = 0; evOverrun = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(0, d); check("R1 status", d, 32'h0);
    busRead(1, d); check("R1 ctrl", d, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    pulse(6'h10);
    busRead(0, d); check("R2 break", d, 32'h10);
    pulse(6'h29);
    repeat (3) @(negedge clk);
    busRead(0, d); check("R2 all held", d, 32'h39);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    busWrite(0, 32'h10);
    busRead(0, d); check("R3 clear break", d, 32'h29);
    busWrite(0, 32'h0);
    busRead(0, d); check("R3 zero write", d, 32'h29);
    busWrite(0, 32'h29);
    busRead(0, d); check("R3 clear rest", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(6'h08);
    busAddr = 0; busWrData = 32'h08; busWrEn = 1'b1; evFrameErr = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0; evFrameErr = 1'b0;
    busRead(0, d); check("R4 collision", d, 32'h08);
    busWrite(0, 32'h08);
    busRead(0, d); check("R4 later clear", d, 32'h0);
  endtask

  task automatic t_live();
    logic [31:0] d;
    rxTrigLvl = 1; @(negedge clk);
    busRead(0, d); check("R5 trig", d, 32'h02);
    rxTimeoutLvl = 1;
    busWrite(0, 32'h06);
    busRead(0, d); check("R5 write no effect", d, 32'h06);
    rxTrigLvl = 0; rxTimeoutLvl = 0; @(negedge clk);
    busRead(0, d); check("R5 drop", d, 32'h0);
  endtask

  task automatic t_txset();
    logic [31:0] d;
    busWrite(0, 32'h40);
    busRead(0, d); check("R6 set via bit6", d, 32'h01);
    busWrite(0, 32'h41);
    busRead(0, d); check("R6 set beats clear", d, 32'h01);
    busWrite(0, 32'h01);
    busRead(0, d); check("R6 clear", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    busWrite(1, 32'hFFFF_FFFF);
    busRead(1, d); check("R7 ctrl mask", d, 32'hE0);
    busRead(2, d); check("R7 other addr", d, 32'h0);
    busWrite(1, 32'h0);
    busWrite(0, 32'hFFFF_FF80);
    busRead(0, d); check("R9 upper write", d, 32'h0);
    pulse(6'h39);
    busWrite(0, 32'hFFFF_FF80);
    busRead(0, d); check("R9 upper no clear", d, 32'h39);
    busWrite(0, 32'h39);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse(6'h10); @(negedge clk);
    check("R8 disabled", {31'b0, irqOut}, 0);
    busWrite(1, 32'h80);
    check("R8 not yet", {31'b0, irqOut}, 0);
    @(negedge clk);
    check("R8 err enabled", {31'b0, irqOut}, 1);
    busWrite(0, 32'h10);
    check("R8 clear lag", {31'b0, irqOut}, 1);
    @(negedge clk);
    check("R8 cleared", {31'b0, irqOut}, 0);
    rxTrigLvl = 1; repeat (2) @(negedge clk);
    check("R8 trig needs rx en", {31'b0, irqOut}, 0);
    busWrite(1, 32'h40); @(negedge clk);
    check("R8 rx en", {31'b0, irqOut}, 1);
    rxTrigLvl = 0; repeat (2) @(negedge clk);
    check("R8 rx drop", {31'b0, irqOut}, 0);
    pulse(6'h01); @(negedge clk);
    check("R8 tx needs tx en", {31'b0, irqOut}, 0);
    busWrite(1, 32'h20); @(negedge clk);
    check("R8 tx en", {31'b0, irqOut}, 1);
    busRead(1, d); check("R7 tx en readback", d, 32'h20);
    busWrite(0, 32'h01); @(negedge clk);
    check("R8 tx cleared", {31'b0, irqOut}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_w1c();
    t_collide();
    t_live();
    t_txset();
    t_regs();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        vecCnt++; errCnt++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule